// File: doc/BRIEF.md
# Serial Converter Frame Controller

This block is the digital control core of a 12-bit serial sampling converter. A host frames each transfer with an active-low select line and clocks it with its own serial clock. Both lines are asynchronous to the block's system clock, so the block first brings them into its own clock domain. A falling edge on the select line opens a frame. The block then drives the previous conversion result onto its serial data pin, most significant bit first, and holds a sample window open for twelve serial clocks. After the sixteenth clock it latches the input word and runs a conversion, which is timed by a divided internal oscillator.

When the conversion finishes, the block emits a one-cycle end-of-conversion pulse, stores the word and powers down until the next frame. If the host raises the select line before the conversion completes, the conversion is abandoned. The next frame then carries a cleared validity flag. The analog sampler is stood in for by a 12-bit parallel input word, which is captured when the sample window closes. The code is straight binary, so 000h is zero scale and FFFh is full scale.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: After reset the data output is not enabled, the power-down flag is 1, the end-of-conversion pulse is 0, and the first frame carries a validity flag of 0.
- R2: A falling edge on `sel_n` while idle starts a frame: `sdo_oe` goes to 1 and `pwr_down` goes to 0.
- R3: A frame shifts out 16 bits, MSB first. Bits 15..4 are the stored result, bits 3..0 are zero. The MSB is presented at frame start, each later bit appears after the 2nd through 16th SCLK rising edge, and the bit read at SCLK falling edge k is bit 16-k.
- R4: `sample_active` is 1 from the 5th SCLK rising edge of a frame until the 16th SCLK falling edge, and 0 at all other times.
- R5: At the 16th SCLK falling edge `sdo_oe` returns to 0, `sample_word` is captured, and a conversion starts. Later changes of `sample_word` do not affect that conversion's result.
- R6: A conversion lasts CONV_CYCLES ticks of the internal conversion clock, each tick being CONV_DIV system clocks. It ends with a one-cycle `eoc` pulse and stores the captured word as the new result.
- R7: A rising edge on `sel_n` during a conversion aborts it. No `eoc` pulse follows, and the next frame shows a validity flag of 0.
- R8: `pwr_down` becomes 1 at end of conversion, at an abort, and at the end of a short frame. It stays 1 until the next `sel_n` falling edge.
- R9: During a frame, `sdo_valid` is 1 exactly when the most recent conversion completed rather than aborted.
- R10: A rising edge on `sel_n` before the 16th SCLK falling edge ends the frame. `sdo_oe` goes to 0, no conversion starts, and the stored result and flag are unchanged.
- R11: SCLK edges while `sel_n` is high have no effect: `sdo_oe` stays 0 and the next frame's word is unaltered.
- R12: Zero-scale 000h and full-scale FFFh words pass through conversion and readout unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also source of the divided conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select / frame sync from host (asynchronous) |
| sclk | input | 1 | Host serial clock (asynchronous) |
| sample_word | input | 12 | Stand-in for the sampled analog value |
| sdo | output | 1 | Serial data, valid only while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable for the tri-state data pin |
| sdo_valid | output | 1 | Validity flag of the word being shifted out |
| sample_active | output | 1 | Sample window open |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| pwr_down | output | 1 | Block is in its powered-down state |

## Verification
The hardest situation to reach from the ports is an abort. It needs a select rising edge that falls inside the conversion window, after the sixteenth serial clock has been seen through the synchronisers but before the divided conversion clock has counted out. The stimulus raises `sel_n` a fixed 20 system clocks after the last falling SCLK edge. That is well inside the roughly 56-cycle conversion, whatever the phase of the free-running divider. The bench also changes `sample_word` during every conversion, which shows that the capture happens at window close and not at completion. Random frame kinds are mixed so that aborts, short frames and completed conversions follow one another in varied orders. This lets the carried validity flag be seen to flip both ways.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   typedef enum logic [1:0] {
      ST_SLEEP = 2'd0,
      ST_SHIFT = 2'd1,
      ST_CONV  = 2'd2
   } sadc_state_t;
endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sadc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
      else        pipe <= {pipe[STAGES-1:0], din};
   end

   assign level = pipe[STAGES-1];
   assign rise  =  pipe[STAGES-1] & ~pipe[STAGES];
   assign fall  = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/sadc_conv_timer.sv
module sadc_conv_timer #(
   parameter int CONV_CYCLES = 14,
   parameter int CONV_DIV    = 4,
   parameter int CW          = $clog2(CONV_CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic          done,
   output logic [CW-1:0] cnt
);
   localparam int DW = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

   logic tick;

   generate
      if (CONV_CYCLES < 1) begin : g_bad_cycles
         $error("sadc_conv_timer: CONV_CYCLES must be positive");
      end
      if (CONV_DIV <= 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           div_q <= '0;
            else if (div_q == DW'(CONV_DIV - 1))  div_q <= '0;
            else                                  div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DW'(CONV_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (tick)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign done = run & tick & (cnt == LAST);
endmodule

// File: rtl/sadc_out_shift.sv
module sadc_out_shift #(
   parameter int FRAME_LEN = 16,
   parameter int RES_W     = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RES_W-1:0] word,
   input  logic             shift,
   output logic             msb
);
   localparam int PAD_W = FRAME_LEN - RES_W;

   logic [FRAME_LEN-1:0] image;
   logic [FRAME_LEN-1:0] sreg;

   generate
      if (PAD_W > 0) begin : g_pad
         assign image = {word, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign image = word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sreg <= '0;
      else if (load)  sreg <= image;
      else if (shift) sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
   end

   assign msb = sreg[FRAME_LEN-1];
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl #(
   parameter int RES_W        = 12,
   parameter int FRAME_LEN    = 16,
   parameter int SAMPLE_START = 5,
   parameter int CONV_CYCLES  = 14,
   parameter int CONV_DIV     = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             sclk,
   input  logic [RES_W-1:0] sample_word,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             sdo_valid,
   output logic             sample_active,
   output logic             eoc,
   output logic             pwr_down
);
   import sadc_pkg::*;

   localparam int CNT_W = $clog2(FRAME_LEN + 1);
   localparam int CW    = $clog2(CONV_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST_CLK  = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] WIN_START = CNT_W'(SAMPLE_START);

   generate
      if (RES_W > FRAME_LEN) begin : g_bad_width
         $error("sadc_frame_ctrl: RES_W exceeds FRAME_LEN");
      end
      if (SAMPLE_START < 1 || SAMPLE_START > FRAME_LEN) begin : g_bad_window
         $error("sadc_frame_ctrl: SAMPLE_START out of frame");
      end
   endgenerate

   logic sel_lvl, sel_rise, sel_fall;
   logic sck_lvl, sck_rise, sck_fall;

   sadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
      .clk(clk), .rst_n(rst_n), .din(sel_n),
      .level(sel_lvl), .rise(sel_rise), .fall(sel_fall));

   sadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .din(sclk),
      .level(sck_lvl), .rise(sck_rise), .fall(sck_fall));

   sadc_state_t       state;
   logic [CNT_W-1:0]  clk_cnt;
   logic [RES_W-1:0]  held_word;
   logic [RES_W-1:0]  rslt;
   logic              rslt_vld;
   logic              frame_vld;
   logic              conv_done;
   logic [CW-1:0]     conv_cnt;
   logic              shift_msb;
   logic              load_frame;
   logic              shift_bit;

   assign load_frame = (state == ST_SLEEP) && sel_fall;
   assign shift_bit  = (state == ST_SHIFT) && !sel_rise && sck_rise &&
                       (clk_cnt != '0) && (clk_cnt < LAST_CLK);

   sadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .CONV_DIV(CONV_DIV), .CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state == ST_CONV),
      .done(conv_done), .cnt(conv_cnt));

   sadc_out_shift #(.FRAME_LEN(FRAME_LEN), .RES_W(RES_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load_frame), .word(rslt),
      .shift(shift_bit), .msb(shift_msb));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_SLEEP;
         clk_cnt   <= '0;
         held_word <= '0;
         rslt      <= '0;
         rslt_vld  <= 1'b0;
         frame_vld <= 1'b0;
      end else begin
         case (state)
            ST_SLEEP: begin
               if (sel_fall) begin
                  state     <= ST_SHIFT;
                  clk_cnt   <= '0;
                  frame_vld <= rslt_vld;
               end
            end
            ST_SHIFT: begin
               if (sel_rise) begin
                  state <= ST_SLEEP;
               end else if (sck_rise && clk_cnt < LAST_CLK) begin
                  clk_cnt <= clk_cnt + 1'b1;
               end else if (sck_fall && clk_cnt == LAST_CLK) begin
                  held_word <= sample_word;
                  state     <= ST_CONV;
               end
            end
            ST_CONV: begin
               if (conv_done) begin
                  rslt     <= held_word;
                  rslt_vld <= 1'b1;
                  state    <= ST_SLEEP;
               end else if (sel_rise) begin
                  rslt_vld <= 1'b0;
                  state    <= ST_SLEEP;
               end
            end
            default: state <= ST_SLEEP;
         endcase
      end
   end

   assign sdo_oe        = (state == ST_SHIFT);
   assign sdo           = sdo_oe & shift_msb;
   assign sdo_valid     = sdo_oe & frame_vld;
   assign sample_active = (state == ST_SHIFT) && (clk_cnt >= WIN_START);
   assign eoc           = conv_done;
   assign pwr_down      = (state == ST_SLEEP);

   logic unused_lvl;
   assign unused_lvl = sel_lvl ^ sck_lvl;
endmodule

// File: rtl/sadc_frame_ctrl_chk.sv
module sadc_frame_ctrl_chk #(
   parameter int CONV_CYCLES = 14,
   parameter int CW          = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sdo_oe,
   input logic          sample_active,
   input logic          eoc,
   input logic          pwr_down,
   input logic          rslt_vld,
   input logic [CW-1:0] conv_cnt
);
   assert_eoc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);

   assert_conv_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_cnt < CW'(CONV_CYCLES));

   assert_eoc_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> pwr_down);

   assert_oe_awake_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !pwr_down);

   assert_window_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_active |-> sdo_oe);

   assert_flag_after_eoc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> rslt_vld);
endmodule

bind sadc_frame_ctrl sadc_frame_ctrl_chk #(.CONV_CYCLES(CONV_CYCLES), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sdo_oe(sdo_oe), .sample_active(sample_active),
   .eoc(eoc), .pwr_down(pwr_down), .rslt_vld(rslt_vld), .conv_cnt(conv_cnt));

// File: tb/sim_sadc_frame_ctrl.sv
module sim_sadc_frame_ctrl;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        sclk = 1'b0;
   logic [11:0] sample_word = '0;
   logic        sdo, sdo_oe, sdo_valid, sample_active, eoc, pwr_down;

   int checks = 0;
   int fails  = 0;
   int eoc_cnt = 0;
   bit done_flag = 0;

   logic [11:0] exp_rslt = '0;
   logic        exp_vld  = 1'b0;

   always #10 clk = ~clk;

   sadc_frame_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk),
      .sample_word(sample_word), .sdo(sdo), .sdo_oe(sdo_oe),
      .sdo_valid(sdo_valid), .sample_active(sample_active),
      .eoc(eoc), .pwr_down(pwr_down));

   always @(posedge clk) if (rst_n && eoc) eoc_cnt <= eoc_cnt + 1;

   function automatic logic [15:0] frame_image(input logic [11:0] w);
      return {w, 4'b0000};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // kind: 0 full conversion, 1 abort during conversion, 2 short frame ending after cut rises
   task automatic run_frame(input int kind, input logic [11:0] w, input int cut);
      logic [15:0] got;
      int e0;
      got = '0;
      sample_word = w;
      sel_n = 1'b0;
      wait_clk(HALF);
      chk("R2 oe", sdo_oe, 1'b1);
      chk("R2 pwr", pwr_down, 1'b0);
      chk("R9 flag", sdo_valid, exp_vld);
      for (int k = 1; k <= 16; k++) begin
         sclk = 1'b1;
         wait_clk(HALF);
         if (kind == 2 && k == cut) begin
            sel_n = 1'b1;
            wait_clk(HALF);
            chk("R10 oe", sdo_oe, 1'b0);
            chk("R8 short pwr", pwr_down, 1'b1);
            chk("R4 short win", sample_active, 1'b0);
            sclk = 1'b0;
            wait_clk(HALF);
            return;
         end
         chk("R4 window", sample_active, (k >= 5));
         got[16-k] = sdo;
         sclk = 1'b0;
         wait_clk(HALF);
      end
      if (exp_vld) chk("R3 word", got[15:4], frame_image(exp_rslt) >> 4);
      chk("R3 pad", got[3:0], 4'h0);
      chk("R5 oe off", sdo_oe, 1'b0);
      chk("R4 win closed", sample_active, 1'b0);
      sample_word = ~w;
      e0 = eoc_cnt;
      if (kind == 1) begin
         wait_clk(20 - HALF);
         sel_n = 1'b1;
         wait_clk(90);
         chk("R7 no eoc", eoc_cnt - e0, 0);
         chk("R8 abort pwr", pwr_down, 1'b1);
         exp_vld = 1'b0;
      end else begin
         wait_clk(90);
         chk("R6 eoc once", eoc_cnt - e0, 1);
         chk("R8 eoc pwr", pwr_down, 1'b1);
         exp_rslt = w;
         exp_vld  = 1'b1;
         sel_n = 1'b1;
      end
      wait_clk(HALF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int seed;
      seed = 32'h5ad0c;
      void'($urandom(seed));
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(4);
      chk("R1 oe", sdo_oe, 1'b0);
      chk("R1 pwr", pwr_down, 1'b1);
      chk("R1 eoc", eoc, 1'b0);
      chk("R1 flag", sdo_valid, 1'b0);

      // R1: first frame carries flag 0, then R12 zero and full scale
      run_frame(0, 12'h000, 0);
      run_frame(0, 12'hFFF, 0);
      run_frame(0, 12'hA5C, 0);   // reads back FFF (R12)
      // R7 abort then R9 flag cleared on next frame
      run_frame(1, 12'h123, 0);
      run_frame(0, 12'h456, 0);
      // R10 short frame keeps result and flag
      run_frame(2, 12'h777, 6);
      run_frame(0, 12'h89A, 0);
      // R11 SCLK activity while idle is ignored
      for (int i = 0; i < 3; i++) begin
         sclk = 1'b1; wait_clk(HALF);
         chk("R11 idle oe", sdo_oe, 1'b0);
         sclk = 1'b0; wait_clk(HALF);
      end
      run_frame(0, 12'h000, 0);   // word 89A must read back intact (R11)

      for (int i = 0; i < 24; i++) begin
         int r, kind;
         r = $urandom_range(0, 99);
         kind = (r < 65) ? 0 : (r < 82) ? 1 : 2;
         run_frame(kind, 12'($urandom_range(0, 4095)), $urandom_range(1, 15));
      end
      run_frame(0, 12'h000, 0);
      finish_run();
   end
endmodule